// File: doc/BRIEF.md
# Sparse Matrix–Dense Vector Multiply-Accumulate Engine

This block computes C += A·B for one block of the result vector C, where A is a sparse matrix streamed in as coordinate tuples and B is a dense vector held entirely in an on-chip table. Before a block is processed, B is written through a simple write port. Tuples then arrive several per beat. Each enabled tuple multiplies its value by B at its column and adds the product into the running sum for its row.

Each lane keeps its own partial sums, so two tuples in one beat that name the same row never collide. Inside a lane, rows are spread across interleaved groups by row index modulo the group count, and each group has its own bank. When the host pulses `drain`, the engine walks the rows of the block in ascending order. For each row it adds the lane partials, emits the low 16 bits and clears the sums, which leaves the block ready for the next one.

The 16-bit row field of a tuple is split in two. Its top bits are lent to the column index as extra high bits, and only the remaining low bits address a row. Values are 16-bit signed. Products and sums are kept at 32 bits.

Top module: `smv_engine`

## Requirements
- R1: Lane l of `beat_data` occupies bits [l·TW +: TW], with TW = 16 + 2·IDX_W. Inside a lane, the column field is the low IDX_W bits, the row field is the next IDX_W bits and the signed value is the top 16 bits. A tuple takes part only when `lane_mask[l]` is 1 in a beat where `beat_valid` is 1.
- R2: The top BORROW bits of the row field become the high bits of the column index, placed above the whole column field. The row index is the remaining IDX_W−BORROW low bits of the row field.
- R3: Each enabled tuple adds value × B[column] into C[row], as a signed 16×16 product accumulated at 32 bits. Several tuples that hit the same row in one beat, and beats that follow each other on consecutive cycles, are all counted without stall.
- R4: When `b_wr_en` is 1, a clock edge writes `b_wr_data` into B at `b_wr_addr`. Tuples that arrive after the write use the new value.
- R5: A `drain` pulse while `busy` is 0 raises `busy` after that edge. The C rows 0 to GROUPS·SLOTS−1 then come out one per cycle in ascending order on `c_row`/`c_data` with `c_valid` high, starting on the second edge after the pulse. `c_last` marks the final row, and `busy` falls on the same edge.
- R6: `c_data` is the low 16 bits of the 32-bit row sum, which wraps modulo 2^32.
- R7: Draining clears every row sum, so the next block starts from zero.
- R8: The engine drops a tuple whose row index is GROUPS·SLOTS or more, or whose column index is 2^B_AW or more. It also ignores a beat presented while `busy` is 1 or in the same cycle as `drain`.
- R9: After reset, `c_valid` and `busy` are 0 and all row sums are zero.
- R10: A beat accepted in the cycle just before the `drain` pulse is included in the rows that drain emits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| b_wr_en | input | 1 | Write enable for the B table |
| b_wr_addr | input | B_AW | B table write address |
| b_wr_data | input | 16 | B element to write |
| beat_valid | input | 1 | Tuple beat present |
| lane_mask | input | LANES | Per-lane tuple enable |
| beat_data | input | LANES·TW | Packed tuples |
| drain | input | 1 | Start emitting and clearing the C block |
| busy | output | 1 | Drain in progress |
| c_valid | output | 1 | Output row valid |
| c_row | output | clog2(GROUPS·SLOTS) | Output row index |
| c_data | output | 16 | Truncated row sum |
| c_last | output | 1 | Final row of the block |

## Verification
The hardest situation to reach from the ports is one where several tuples in a single beat, and in beats on consecutive cycles, land on the same row while their column indices depend on the borrowed row bits. The stimulus sets up directed beats that aim every lane at one row, with columns whose high bits come only from the row field. It then sends random back-to-back beats whose unrestricted row and column fields also produce out-of-range indices. Further directed cases place a beat immediately before the drain pulse, in the same cycle as the pulse, and in the middle of a drain. Another pushes the sum past 32 bits so that both the wrap and the 16-bit truncation are visible.

// File: rtl/smv_pkg.sv
package smv_pkg;
  localparam int unsigned VAL_W = 16;
  localparam int unsigned ACC_W = 32;

  typedef logic signed [VAL_W-1:0] val_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  // signed product widened to accumulator width, added with wraparound
  function automatic acc_t mac_step(input acc_t acc, input val_t a, input val_t b);
    acc_t prod;
    prod = acc_t'(a) * acc_t'(b);
    return acc + prod;
  endfunction

  function automatic val_t trunc_out(input acc_t s);
    return val_t'(s);
  endfunction
endpackage

// File: rtl/smv_bvec_ram.sv
module smv_bvec_ram
  import smv_pkg::*;
#(
  parameter int AW    = 10,
  parameter int PORTS = 8
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  val_t                      wr_data,
  input  logic [PORTS-1:0][AW-1:0]  rd_addr,
  output val_t                      rd_data [PORTS]
);
  localparam int DEPTH = 2 ** AW;

  val_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    always_ff @(posedge clk) begin
      rd_data[p] <= mem[rd_addr[p]];
    end
  end
endmodule

// File: rtl/smv_lane_acc.sv
module smv_lane_acc
  import smv_pkg::*;
#(
  parameter int GROUPS = 12,
  parameter int SLOTS  = 8,
  parameter int RW     = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_row,
  input  val_t          wr_a,
  input  val_t          wr_b,
  input  logic [RW-1:0] rd_row,
  input  logic          rd_clr,
  output acc_t          rd_val
);
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // interleave: group = row mod GROUPS, slot = row / GROUPS
  logic [GW-1:0] wr_grp, rd_grp;
  logic [SW-1:0] wr_slot, rd_slot;

  assign wr_grp  = GW'(32'(wr_row) % GROUPS);
  assign wr_slot = SW'(32'(wr_row) / GROUPS);
  assign rd_grp  = GW'(32'(rd_row) % GROUPS);
  assign rd_slot = SW'(32'(rd_row) / GROUPS);

  acc_t grp_rd [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    acc_t bank [SLOTS];
    logic hit_wr, hit_clr;
    assign hit_wr  = wr_en  && (wr_grp == GW'(g));
    assign hit_clr = rd_clr && (rd_grp == GW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SLOTS; s++) bank[s] <= '0;
      end else begin
        if (hit_wr)  bank[wr_slot] <= mac_step(bank[wr_slot], wr_a, wr_b);
        if (hit_clr) bank[rd_slot] <= '0;
      end
    end

    assign grp_rd[g] = bank[rd_slot];
  end

  assign rd_val = grp_rd[rd_grp];
endmodule

// File: rtl/smv_engine.sv
module smv_engine
  import smv_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int GROUPS = 12,
  parameter int SLOTS  = 8,
  parameter int IDX_W  = 16,
  parameter int BORROW = 2,
  parameter int B_AW   = 10
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      b_wr_en,
  input  logic [B_AW-1:0]                           b_wr_addr,
  input  logic [15:0]                               b_wr_data,
  input  logic                                      beat_valid,
  input  logic [LANES-1:0]                          lane_mask,
  input  logic [LANES*(16+2*IDX_W)-1:0]             beat_data,
  input  logic                                      drain,
  output logic                                      busy,
  output logic                                      c_valid,
  output logic [$clog2(GROUPS*SLOTS)-1:0]           c_row,
  output logic [15:0]                               c_data,
  output logic                                      c_last
);
  localparam int RW     = IDX_W - BORROW;
  localparam int CW     = IDX_W + BORROW;
  localparam int TW     = VAL_W + 2 * IDX_W;
  localparam int C_ROWS = GROUPS * SLOTS;
  localparam int OW     = $clog2(C_ROWS);

  function automatic logic [RW-1:0] row_of(input logic [IDX_W-1:0] rf);
    return rf[RW-1:0];
  endfunction

  function automatic logic [CW-1:0] col_of(input logic [IDX_W-1:0] rf,
                                           input logic [IDX_W-1:0] cf);
    return {rf[IDX_W-1 -: BORROW], cf};
  endfunction

  // named events for the checker
  logic draining;
  logic blk_start;
  logic beat_take;
  logic [OW-1:0] drain_idx;

  assign blk_start = drain && !draining;
  assign beat_take = beat_valid && !draining && !drain;
  assign busy      = draining;

  logic [LANES-1:0][B_AW-1:0] b_rd_addr;
  val_t                       b_q [LANES];
  logic [LANES-1:0]           s_en;
  logic [RW-1:0]              s_row [LANES];
  val_t                       s_val [LANES];
  acc_t                       lane_rd [LANES];

  smv_bvec_ram #(.AW(B_AW), .PORTS(LANES)) u_bvec (
    .clk     (clk),
    .wr_en   (b_wr_en),
    .wr_addr (b_wr_addr),
    .wr_data (val_t'(b_wr_data)),
    .rd_addr (b_rd_addr),
    .rd_data (b_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [TW-1:0]    tup;
    logic [IDX_W-1:0] colf, rowf;
    val_t             valf;
    logic [RW-1:0]    ridx;
    logic [CW-1:0]    cidx;
    logic             in_range;

    assign tup      = beat_data[l*TW +: TW];
    assign colf     = tup[IDX_W-1:0];
    assign rowf     = tup[2*IDX_W-1:IDX_W];
    assign valf     = val_t'(tup[TW-1 -: VAL_W]);
    assign ridx     = row_of(rowf);
    assign cidx     = col_of(rowf, colf);
    assign in_range = (32'(ridx) < C_ROWS) && ((32'(cidx) >> B_AW) == 0);
    assign b_rd_addr[l] = cidx[B_AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_en[l]  <= 1'b0;
        s_row[l] <= '0;
        s_val[l] <= '0;
      end else begin
        s_en[l]  <= beat_take && lane_mask[l] && in_range;
        s_row[l] <= ridx;
        s_val[l] <= valf;
      end
    end

    smv_lane_acc #(.GROUPS(GROUPS), .SLOTS(SLOTS), .RW(RW)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (s_en[l]),
      .wr_row (s_row[l]),
      .wr_a   (s_val[l]),
      .wr_b   (b_q[l]),
      .rd_row (RW'(drain_idx)),
      .rd_clr (draining),
      .rd_val (lane_rd[l])
    );
  end

  acc_t row_sum;
  always_comb begin
    row_sum = '0;
    for (int l = 0; l < LANES; l++) row_sum = row_sum + lane_rd[l];
  end

  logic at_last;
  assign at_last = (32'(drain_idx) == C_ROWS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      draining  <= 1'b0;
      drain_idx <= '0;
      c_valid   <= 1'b0;
      c_row     <= '0;
      c_data    <= '0;
      c_last    <= 1'b0;
    end else if (blk_start) begin
      draining  <= 1'b1;
      drain_idx <= '0;
      c_valid   <= 1'b0;
      c_last    <= 1'b0;
    end else if (draining) begin
      c_valid   <= 1'b1;
      c_row     <= drain_idx;
      c_data    <= trunc_out(row_sum);
      c_last    <= at_last;
      drain_idx <= drain_idx + 1'b1;
      if (at_last) draining <= 1'b0;
    end else begin
      c_valid <= 1'b0;
      c_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/smv_engine_chk.sv
module smv_engine_chk #(
  parameter int ROWS = 96,
  parameter int OW   = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          drain,
  input logic          busy,
  input logic          c_valid,
  input logic [OW-1:0] c_row,
  input logic          c_last
);
  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain && !busy |=> busy);

  // R5
  first_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> c_valid && c_row == '0);

  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid && !c_last |=> c_valid && c_row == OW'($past(c_row) + 1'b1));

  // R5
  last_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_last |-> c_valid && 32'(c_row) == ROWS - 1 && !busy);

  // R5
  out_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> $past(busy));

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !c_valid && !busy);
endmodule

bind smv_engine smv_engine_chk #(.ROWS(C_ROWS), .OW(OW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .drain   (drain),
  .busy    (busy),
  .c_valid (c_valid),
  .c_row   (c_row),
  .c_last  (c_last)
);

// File: tb/smv_engine_test.sv
module smv_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int GROUPS = 4;
  localparam int SLOTS = 3;
  localparam int IDX_W = 6;
  localparam int BORROW = 2;
  localparam int B_AW = 7;
  localparam int TW = 16 + 2 * IDX_W;
  localparam int ROWS = GROUPS * SLOTS;
  localparam int OW = $clog2(ROWS);
  localparam int BDEPTH = 2 ** B_AW;

  logic clk = 0;
  logic rst_n = 0;
  logic b_wr_en = 0;
  logic [B_AW-1:0] b_wr_addr = '0;
  logic [15:0] b_wr_data = '0;
  logic beat_valid = 0;
  logic [LANES-1:0] lane_mask = '0;
  logic [LANES*TW-1:0] beat_data = '0;
  logic drain = 0;
  logic busy, c_valid, c_last;
  logic [OW-1:0] c_row;
  logic [15:0] c_data;

  smv_engine #(.LANES(LANES), .GROUPS(GROUPS), .SLOTS(SLOTS), .IDX_W(IDX_W),
               .BORROW(BORROW), .B_AW(B_AW)) uut (
    .clk(clk), .rst_n(rst_n), .b_wr_en(b_wr_en), .b_wr_addr(b_wr_addr),
    .b_wr_data(b_wr_data), .beat_valid(beat_valid), .lane_mask(lane_mask),
    .beat_data(beat_data), .drain(drain), .busy(busy), .c_valid(c_valid),
    .c_row(c_row), .c_data(c_data), .c_last(c_last));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;
  logic [15:0] bm [BDEPTH];
  logic signed [31:0] cm [ROWS];
  logic [15:0] t_val [LANES];
  logic [IDX_W-1:0] t_row [LANES];
  logic [IDX_W-1:0] t_col [LANES];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic signed [31:0] prod32(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] x, y;
    x = {{16{a[15]}}, a};
    y = {{16{b[15]}}, b};
    return x * y;
  endfunction

  task automatic write_b(input int addr, input logic [15:0] d);  // R4
    b_wr_en = 1; b_wr_addr = B_AW'(addr); b_wr_data = d;
    bm[addr] = d;
    @(negedge clk);
    b_wr_en = 0;
  endtask

  // R1: lane layout {value, row field, column field}; R2: column = {row[5:4], col}
  task automatic put_beat(input bit counted);
    for (int l = 0; l < LANES; l++) begin
      beat_data[l*TW +: TW] = {t_val[l], t_row[l], t_col[l]};
      if (counted && lane_mask[l]) begin
        int r, c;
        r = int'(t_row[l][IDX_W-BORROW-1:0]);
        c = int'({t_row[l][IDX_W-1 -: BORROW], t_col[l]});
        if (r < ROWS && c < BDEPTH) cm[r] = cm[r] + prod32(t_val[l], bm[c]);
      end
    end
    beat_valid = 1;
  endtask

  task automatic rand_lanes();
    for (int l = 0; l < LANES; l++) begin
      t_val[l] = 16'($urandom);
      t_row[l] = IDX_W'($urandom);
      t_col[l] = IDX_W'($urandom);
    end
    lane_mask = LANES'($urandom);
  endtask

  // R5 ordering/timing, R6 truncation, R7 clear, R8 busy-beat ignore
  task automatic drain_check(input string req, input bit beat_with_drain);
    if (beat_with_drain) begin
      rand_lanes(); lane_mask = '1; put_beat(0);   // R8: same cycle as drain
    end else beat_valid = 0;
    drain = 1;
    @(negedge clk);
    drain = 0; beat_valid = 0;
    check(busy === 1'b1, "R5", "busy after drain", busy, 1);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      beat_valid = 0;
      check(c_valid === 1'b1 && c_row === OW'(r) && c_last === (r == ROWS - 1),
            "R5", {req, " row order"}, {c_valid, c_last, c_row}, {1'b1, r == ROWS - 1, OW'(r)});
      check(c_data === cm[r][15:0], req, $sformatf("row %0d data", r), c_data, cm[r][15:0]);
      if (r == 2) begin
        rand_lanes(); lane_mask = '1; put_beat(0);  // R8: beat while busy
      end
    end
    check(busy === 1'b0, "R5", "busy falls with last", busy, 0);
    @(negedge clk);
    check(c_valid === 1'b0, "R5", "valid drops", c_valid, 0);
    for (int r = 0; r < ROWS; r++) cm[r] = '0;  // R7: block cleared
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < ROWS; r++) cm[r] = '0;
    repeat (3) @(negedge clk);
    check(c_valid === 1'b0 && busy === 1'b0, "R9", "reset outputs", {c_valid, busy}, 0);
    rst_n = 1;
    @(negedge clk);
    check(c_valid === 1'b0 && busy === 1'b0, "R9", "after reset", {c_valid, busy}, 0);
    for (int a = 0; a < BDEPTH; a++) write_b(a, 16'($urandom));
    drain_check("R9", 0);

    // R2/R4: borrowed bits form column 0x49; B rewritten just before
    write_b(8'h49, 16'h0123);
    lane_mask = 4'b0100;
    for (int l = 0; l < LANES; l++) begin t_val[l] = 0; t_row[l] = 0; t_col[l] = 0; end
    t_val[2] = 16'd3; t_row[2] = {2'b01, 4'd5}; t_col[2] = 6'd9;
    put_beat(1); @(negedge clk); beat_valid = 0;
    check(cm[5] == 32'h369, "R2", "model column join", cm[5], 32'h369);
    drain_check("R4", 0);

    // R3: every lane on row 7, then a back-to-back beat on row 7
    lane_mask = '1;
    for (int l = 0; l < LANES; l++) begin
      t_val[l] = 16'(l + 1); t_row[l] = 6'd7; t_col[l] = IDX_W'(l * 3);
    end
    put_beat(1); @(negedge clk);
    for (int l = 0; l < LANES; l++) t_val[l] = 16'hFFFF - 16'(l);
    put_beat(1); @(negedge clk); beat_valid = 0;
    drain_check("R3", 0);

    // R6: products of 0x7fff pushed past 32 bits
    write_b(8'h11, 16'h7FFF);
    lane_mask = '1;
    for (int l = 0; l < LANES; l++) begin t_val[l] = 16'h7FFF; t_row[l] = 6'd1; t_col[l] = 6'h11; end
    repeat (9) begin put_beat(1); @(negedge clk); end
    beat_valid = 0;
    drain_check("R6", 0);

    // R8: out-of-range rows (12..15) and columns (>=128), masked lanes
    lane_mask = 4'b0111;
    for (int l = 0; l < LANES; l++) begin t_val[l] = 16'd5; t_col[l] = 6'd2; end
    t_row[0] = 6'd12; t_row[1] = 6'd15; t_row[2] = {2'b10, 4'd3}; t_row[3] = 6'd4;
    put_beat(1); @(negedge clk); beat_valid = 0;
    drain_check("R8", 0);

    // R10: beat in the cycle before drain; another beat with the pulse
    lane_mask = '1;
    for (int l = 0; l < LANES; l++) begin t_val[l] = 16'd9; t_row[l] = IDX_W'(l); t_col[l] = 6'd1; end
    put_beat(1); @(negedge clk);
    drain_check("R10", 1);

    // R1/R7: random back-to-back blocks, each starting from zero
    for (int blk = 0; blk < 3; blk++) begin
      for (int k = 0; k < 30; k++) begin rand_lanes(); put_beat(1); @(negedge clk); end
      beat_valid = 0;
      drain_check(blk == 0 ? "R1" : "R7", 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule